// File: doc/BRIEF.md
# Carry-Save Array Multiplier

This block multiplies two unsigned operands, an M-bit multiplicand and an N-bit multiplier, entirely in combinational logic. The result is the full (M+N)-bit product, and the block has no clock and no state. Each multiplicand bit is ANDed with each multiplier bit to form the partial products. A regular grid of adder cells then reduces them. Both operand buses are broadcast to every row of the grid.

Inside the grid, each cell sends its carry down to the row below and never along its own row, so no row contains a ripple chain. Each row adds one more multiplier weight. Row 0 holds only the gated bits of the first multiplier bit. The next row uses half adders. Every later row uses full adders, except for a half adder at its top position. The cell at the least significant end of each row emits one finished low-order product bit. After the last row, a sum vector and a carry vector remain. A short ripple adder merges them into the upper M product bits.

The operand widths are parameters with a default of 4 by 4. Each width must be at least 2.

Top module: `csm_multiplier`

## Requirements
- R1: For every pair of unsigned operands, `product` equals the arithmetic product of `op_x` and `op_y`.
- R2: The product is M+N bits wide, and no bit is lost at the top. With both operands all ones, `product` equals (2^M-1)*(2^N-1), and its most significant bit is 1.
- R3: `product[0]` equals `op_x[0] & op_y[0]`. Product bits 0 to N-1 come from the least significant cell of each array row.
- R4: If either operand is zero, `product` is all zeros.
- R5: If one operand is 1, `product` equals the other operand, zero-extended to M+N bits.
- R6: If `op_y` is a power of two 2^k, `product` equals `op_x` shifted left by k places.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_x | input | M | Unsigned multiplicand |
| op_y | input | N | Unsigned multiplier |
| product | output | M+N | Unsigned full-width product |

## Verification
At the 4x4 default, the bench applies all 256 operand pairs and compares each result with the integer product computed in the bench. A zero operand shows whether any adder cell produces a spurious one. An operand of one shows whether the other operand passes through the grid unshifted. A single-bit multiplier shows that each row adds at the correct weight. The all-ones pair drives every carry in the grid and the merge adder, which exposes a dropped carry or a lost top bit. Bit 0 is checked on its own for every pair, so the grid edge is checked separately from the merge adder.

// File: rtl/csm_pkg.sv
package csm_pkg;

  // Result of one single-bit addition cell.
  typedef struct packed {
    logic carry;
    logic sum;
  } csm_bit_sum_t;

  // Number of merge-adder positions for a given multiplicand width.
  function automatic int csm_merge_len(input int m);
    return m - 1;
  endfunction

endpackage

// File: rtl/csm_half_adder.sv
module csm_half_adder (
  input  logic a,
  input  logic b,
  output logic s,
  output logic co
);
  import csm_pkg::*;

  csm_bit_sum_t res;

  always_comb begin
    res.sum   = a ^ b;
    res.carry = a & b;
  end

  assign s  = res.sum;
  assign co = res.carry;
endmodule

// File: rtl/csm_full_adder.sv
module csm_full_adder (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  import csm_pkg::*;

  csm_bit_sum_t res;
  logic         half;

  always_comb begin
    half      = a ^ b;
    res.sum   = half ^ ci;
    res.carry = (a & b) | (half & ci);
  end

  assign s  = res.sum;
  assign co = res.carry;
endmodule

// File: rtl/csm_pp_gen.sv
module csm_pp_gen #(
  parameter int M = 4,
  parameter int N = 4
) (
  input  logic [M-1:0]        op_x,
  input  logic [N-1:0]        op_y,
  output logic [N-1:0][M-1:0] pp
);
  // Operand bits are broadcast to every row. Row j gates the multiplicand
  // with multiplier bit j, at weight 2^(i+j).
  for (genvar j = 0; j < N; j++) begin : g_pp_row
    for (genvar i = 0; i < M; i++) begin : g_pp_col
      assign pp[j][i] = op_x[i] & op_y[j];
    end
  end
endmodule

// File: rtl/csm_array.sv
module csm_array #(
  parameter int M = 4,
  parameter int N = 4
) (
  input  logic [N-1:0][M-1:0] pp,
  output logic [N-1:0]        low_bits,
  output logic [M-1:0]        last_sum,
  output logic [M-1:0]        last_carry
);
  // Row j: sum bit i has weight i+j, and carry bit i has weight i+j+1.
  // Carries move to the next row. Nothing ripples within a row.
  for (genvar j = 0; j < N; j++) begin : g_row
    logic [M-1:0] s;
    logic [M-1:0] c;

    if (j == 0) begin : g_top
      assign s = pp[0];
      assign c = '0;
    end else if (j == 1) begin : g_ha_row
      for (genvar i = 0; i < M; i++) begin : g_cell
        if (i < M - 1) begin : g_ha
          csm_half_adder u_ha (
            .a (pp[j][i]),
            .b (g_row[j-1].s[i+1]),
            .s (s[i]),
            .co(c[i])
          );
        end else begin : g_pass
          assign s[i] = pp[j][i];
          assign c[i] = 1'b0;
        end
      end
    end else begin : g_fa_row
      for (genvar i = 0; i < M; i++) begin : g_cell
        if (i < M - 1) begin : g_fa
          csm_full_adder u_fa (
            .a (pp[j][i]),
            .b (g_row[j-1].s[i+1]),
            .ci(g_row[j-1].c[i]),
            .s (s[i]),
            .co(c[i])
          );
        end else begin : g_edge
          csm_half_adder u_ha (
            .a (pp[j][i]),
            .b (g_row[j-1].c[i]),
            .s (s[i]),
            .co(c[i])
          );
        end
      end
    end

    assign low_bits[j] = s[0];
  end

  assign last_sum   = g_row[N-1].s;
  assign last_carry = g_row[N-1].c;
endmodule

// File: rtl/csm_merge_adder.sv
module csm_merge_adder #(
  parameter int M = 4
) (
  input  logic [M-1:0] last_sum,
  input  logic [M-1:0] last_carry,
  output logic [M-1:0] high_bits
);
  import csm_pkg::*;

  localparam int L = csm_merge_len(M);

  logic [L-1:0] rip;

  // Position k has weight N+k. Its inputs are sum bit k+1 and carry bit k of the last row.
  for (genvar k = 0; k < L; k++) begin : g_merge
    if (k == 0) begin : g_first
      csm_half_adder u_ha (
        .a (last_sum[k+1]),
        .b (last_carry[k]),
        .s (high_bits[k]),
        .co(rip[k])
      );
    end else begin : g_rest
      csm_full_adder u_fa (
        .a (last_sum[k+1]),
        .b (last_carry[k]),
        .ci(rip[k-1]),
        .s (high_bits[k]),
        .co(rip[k])
      );
    end
  end

  // Both terms carry weight M+N-1. The product fits in M+N bits, so at most one of them is set.
  assign high_bits[M-1] = rip[L-1] ^ last_carry[M-1];

  logic unused_lsb;
  assign unused_lsb = last_sum[0];
endmodule

// File: rtl/csm_multiplier.sv
module csm_multiplier #(
  parameter int M = 4,
  parameter int N = 4
) (
  input  logic [M-1:0]   op_x,
  input  logic [N-1:0]   op_y,
  output logic [M+N-1:0] product
);
  localparam int PW = M + N;

  logic [N-1:0][M-1:0] pp;
  logic [N-1:0]        low_bits;
  logic [M-1:0]        last_sum;
  logic [M-1:0]        last_carry;
  logic [M-1:0]        high_bits;

  csm_pp_gen #(.M(M), .N(N)) u_pp (
    .op_x(op_x),
    .op_y(op_y),
    .pp  (pp)
  );

  csm_array #(.M(M), .N(N)) u_arr (
    .pp        (pp),
    .low_bits  (low_bits),
    .last_sum  (last_sum),
    .last_carry(last_carry)
  );

  csm_merge_adder #(.M(M)) u_merge (
    .last_sum  (last_sum),
    .last_carry(last_carry),
    .high_bits (high_bits)
  );

  assign product[N-1:0]  = low_bits;
  assign product[PW-1:N] = high_bits;
endmodule

// File: rtl/csm_multiplier_checker.sv
module csm_multiplier_checker #(
  parameter int M = 4,
  parameter int N = 4
) (
  input logic [M-1:0]   op_x,
  input logic [N-1:0]   op_y,
  input logic [M+N-1:0] product
);
  localparam int PW = M + N;

  logic [PW-1:0] ref_prod;
  logic [PW-1:0] x_ext;
  logic [PW-1:0] y_ext;

  always_comb begin
    x_ext    = PW'(op_x);
    y_ext    = PW'(op_y);
    ref_prod = x_ext * y_ext;

    assert_product_match_R1: assert (product == ref_prod)
      else $error("R1 product %0h expected %0h", product, ref_prod);

    if (&op_x && &op_y)
      assert_top_bit_R2: assert (product[PW-1])
        else $error("R2 top bit clear for all-ones operands");

    assert_lsb_and_R3: assert (product[0] == (op_x[0] & op_y[0]))
      else $error("R3 bit 0 mismatch");

    if (op_x == '0 || op_y == '0)
      assert_zero_operand_R4: assert (product == '0)
        else $error("R4 nonzero product with zero operand");

    if (op_y == N'(1))
      assert_unit_y_R5: assert (product == x_ext)
        else $error("R5 product differs from op_x");

    if (op_x == M'(1))
      assert_unit_x_R5: assert (product == y_ext)
        else $error("R5 product differs from op_y");

    if ($onehot(op_y))
      assert_shift_R6: assert (product == ref_prod)
        else $error("R6 power-of-two multiplier mismatch");
  end
endmodule

bind csm_multiplier csm_multiplier_checker #(.M(M), .N(N)) u_chk (
  .op_x   (op_x),
  .op_y   (op_y),
  .product(product)
);

// File: tb/csm_multiplier_bench.sv
module csm_multiplier_bench;
  localparam int M  = 4;
  localparam int N  = 4;
  localparam int PW = M + N;

  logic          clk;
  logic          rst_n;
  logic [M-1:0]  op_x;
  logic [N-1:0]  op_y;
  logic [PW-1:0] product;

  int n_checks;
  int n_fail;
  bit done;

  csm_multiplier #(.M(M), .N(N)) u_csm_multiplier (
    .op_x   (op_x),
    .op_y   (op_y),
    .product(product)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input logic [PW-1:0] act,
                       input logic [PW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s x=%0d y=%0d actual=%0d expected=%0d",
               req, op_x, op_y, act, exp);
    end
  endtask

  task automatic apply(input int xv, input int yv);
    @(negedge clk);
    op_x = M'(xv);
    op_y = N'(yv);
    #1;
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    op_x     = '0;
    op_y     = '0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #1;
    // Start-up state: zero operands give a zero product (R4).
    check("R4", product, '0);

    for (int xv = 0; xv < (1 << M); xv++) begin
      for (int yv = 0; yv < (1 << N); yv++) begin
        int exp_i;
        apply(xv, yv);
        exp_i = xv * yv;
        check("R1", product, PW'(exp_i));
        check("R3", PW'(product[0]), PW'((xv & yv) & 1));
        if (xv == 0 || yv == 0) check("R4", product, '0);
        if (yv == 1) check("R5", product, PW'(xv));
        if (xv == 1) check("R5", product, PW'(yv));
        if (yv != 0 && (yv & (yv - 1)) == 0)
          check("R6", product, PW'(xv) << $clog2(yv));
      end
    end

    apply((1 << M) - 1, (1 << N) - 1);
    check("R2", product, PW'(((1 << M) - 1) * ((1 << N) - 1)));
    check("R2", PW'(product[PW-1]), PW'(1));

    done = 1'b1;
  end

  initial begin
    int cycles;
    cycles = 0;
    while (!done && cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=done", cycles);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule